// File: doc/BRIEF.md
# Time-Slice Output Frame Sequencer

This block builds the outgoing word stream of a pad-readout front end. Time is cut into slices, and each slice holds exactly two 11-bit word slots. Each slot is marked by a one-cycle strobe. When nothing has been triggered, every slice carries a sync word and then a status word.

A trigger pulse captures the hit pattern and the timestamp into a small queue. At the start of the next slice, the sequencer takes the oldest queued entry and sends that slice as a normal sync/status pair, which is the triggered slice. Then come 12 frame slices. In each frame slice, the first slot carries one frame word and the second slot carries the status word. The frame words are a sync, then the timestamp as time words, then the hit pattern as data words. If a trigger arrives while the queue is full, it is dropped, and the drop is reported in status bit 0.

The core clock runs `CLK_PER_WORD` times faster than the word rate. With the default of 5 and a 100 MHz core clock, a word goes out at 20 MHz, which gives a slice of 100 ns.

Top module: `slice_frame_seq`

## Requirements
- R1: While `rst_i` is high, `word_o` is 0 and `word_stb_o` is 0.
- R2: `word_stb_o` pulses for one cycle every `CLK_PER_WORD` cycles, first in cycle `CLK_PER_WORD` after reset release. `word_o` changes only together with a strobe.
- R3: Word encodings:
  - sync is 11'b000_0000_0001;
  - status is {3'b111, S[7:0]};
  - time is {3'b110, byte};
  - data is {3'b101, byte}.
  - Only the sync word has bits [10:8] equal to 000.
- R4: Strobes alternate between a first slot and a second slot, starting with the first slot. Every second-slot word is a status word. An idle slice is a sync word followed by a status word.
- R5: A status word carries `status_i` as sampled in its strobe cycle. The exception is bit 0, which is `status_i[0]` OR a pending drop flag.
- R6: A queued trigger makes the next slice the triggered slice (sync, status). The 12 slices that follow are frame slices, each made of one frame word and then a status word. After the last frame slice, idle slices resume.
- R7: Frame word order:
  - first, the sync word;
  - then 3 time words, timestamp bits [7:0] first;
  - then 8 data words, hit bits [7:0] first.
- R8: Triggers are queued first-in first-out in a `FIFO_DEPTH`-entry queue (default 4). A trigger queued during a frame gets its own triggered slice directly after that frame ends.
- R9: A trigger that arrives with the queue full, and with no entry leaving in that cycle, is dropped. It sets the drop flag. The next status word reports the flag in bit 0, and sending that status word clears the flag.
- R10: A frame carries the `hits_i`/`tstamp_i` values present in its trigger cycle. Later changes on those inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | One-cycle strobe: capture hits and timestamp |
| hits_i | input | HIT_W | Captured hit pattern (default 64) |
| tstamp_i | input | TS_W | Timestamp (default 24) |
| status_i | input | 8 | Status bits placed in status words |
| word_o | output | 11 | Output word |
| word_stb_o | output | 1 | Word strobe, one cycle per word slot |

## Verification
The bench builds the block with `CLK_PER_WORD` = 3 and `FIFO_DEPTH` = 2. A slice then lasts only 6 cycles, so several complete triggered frames, including back-to-back queued ones, fit into a short run. The shallow queue means four triggers in consecutive cycles are certain to overflow it, which brings the drop-and-report path of status bit 0 and its clearing within reach. The queue-full boundary is also exercised.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int WORD_W = 11;
    localparam int MARK_W = 3;
    localparam int PAY_W  = WORD_W - MARK_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t            SYNC_WORD = 11'b000_0000_0001;
    localparam logic [MARK_W-1:0] MK_STATUS = 3'b111;
    localparam logic [MARK_W-1:0] MK_TIME   = 3'b110;
    localparam logic [MARK_W-1:0] MK_DATA   = 3'b101;

    function automatic word_t pack_word(logic [MARK_W-1:0] mk, logic [PAY_W-1:0] pay);
        return {mk, pay};
    endfunction
endpackage

// File: rtl/sfs_tick.sv
module sfs_tick #(
    parameter int CLK_PER_WORD = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_WORD > 1) ? $clog2(CLK_PER_WORD) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CW'(CLK_PER_WORD - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfs_trig_fifo.sv
module sfs_trig_fifo #(
    parameter int ENTRY_W = 88,
    parameter int DEPTH   = 4,
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] din_i,
    input  logic               pop_i,
    output logic [ENTRY_W-1:0] dout_o,
    output logic               empty_o,
    output logic               full_o,
    output logic               drop_o,
    output logic [CNT_W-1:0]   count_o
);
    typedef struct packed {
        logic [PW-1:0]    rd;
        logic [PW-1:0]    wr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [ENTRY_W-1:0] mem_d [DEPTH];
    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty_o = (s_q.cnt == '0);
        full_o  = (s_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop_i && !empty_o;
        do_push = push_i && (!full_o || do_pop);
        drop_o  = push_i && full_o && !do_pop;
        dout_o  = mem_q[s_q.rd];
        count_o = s_q.cnt;

        s_d   = s_q;
        mem_d = mem_q;
        if (do_push) begin
            mem_d[s_q.wr] = din_i;
            s_d.wr        = wrap_inc(s_q.wr);
        end
        if (do_pop) s_d.rd = wrap_inc(s_q.rd);
        s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    always_ff @(posedge clk_i) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/sfs_frame_fmt.sv
module sfs_frame_fmt
    import sfs_pkg::*;
#(
    parameter int HIT_W   = 64,
    parameter int TS_W    = 24,
    localparam int N_TIME  = TS_W / PAY_W,
    localparam int N_DATA  = HIT_W / PAY_W,
    localparam int N_WORDS = 1 + N_TIME + N_DATA,
    localparam int IDX_W   = $clog2(N_WORDS)
) (
    input  logic [HIT_W-1:0] hits_i,
    input  logic [TS_W-1:0]  tstamp_i,
    input  logic [IDX_W-1:0] idx_i,
    output word_t            word_o
);
    word_t words [N_WORDS];

    assign words[0] = SYNC_WORD;

    for (genvar k = 0; k < N_TIME; k++) begin : g_time
        assign words[1 + k] = pack_word(MK_TIME, tstamp_i[k*PAY_W +: PAY_W]);
    end

    for (genvar j = 0; j < N_DATA; j++) begin : g_data
        assign words[1 + N_TIME + j] = pack_word(MK_DATA, hits_i[j*PAY_W +: PAY_W]);
    end

    always_comb begin
        word_o = SYNC_WORD;
        for (int k = 0; k < N_WORDS; k++) begin
            if (idx_i == IDX_W'(k)) word_o = words[k];
        end
    end
endmodule

// File: rtl/slice_frame_seq.sv
module slice_frame_seq
    import sfs_pkg::*;
#(
    parameter int HIT_W        = 64,
    parameter int TS_W         = 24,
    parameter int FIFO_DEPTH   = 4,
    parameter int CLK_PER_WORD = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              trig_i,
    input  logic [HIT_W-1:0]  hits_i,
    input  logic [TS_W-1:0]   tstamp_i,
    input  logic [7:0]        status_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o
);
    localparam int N_TIME      = TS_W / PAY_W;
    localparam int N_DATA      = HIT_W / PAY_W;
    localparam int FRAME_WORDS = 1 + N_TIME + N_DATA;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int ENT_W       = HIT_W + TS_W;
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic             slot;      // 0: first slot of slice, 1: status slot
        logic             armed;     // triggered slice in progress
        logic             in_frame;
        logic [IDX_W-1:0] fidx;
        logic             ovf;
        logic [ENT_W-1:0] frame;     // {hits, tstamp}
        word_t            word;
        logic             stb;
    } seq_t;

    seq_t s_d, s_q;

    logic             tick;
    logic             q_pop, q_empty, q_full, q_drop;
    logic [ENT_W-1:0] q_dout;
    logic [CNT_W-1:0] q_cnt;
    word_t            fmt_word;

    sfs_tick #(.CLK_PER_WORD(CLK_PER_WORD)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    sfs_trig_fifo #(.ENTRY_W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (trig_i),
        .din_i   ({hits_i, tstamp_i}),
        .pop_i   (q_pop),
        .dout_o  (q_dout),
        .empty_o (q_empty),
        .full_o  (q_full),
        .drop_o  (q_drop),
        .count_o (q_cnt)
    );

    sfs_frame_fmt #(.HIT_W(HIT_W), .TS_W(TS_W)) u_fmt (
        .hits_i   (s_q.frame[ENT_W-1:TS_W]),
        .tstamp_i (s_q.frame[TS_W-1:0]),
        .idx_i    (s_q.fidx),
        .word_o   (fmt_word)
    );

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        q_pop   = 1'b0;

        if (tick) begin
            s_d.stb  = 1'b1;
            s_d.slot = ~s_q.slot;
            if (!s_q.slot) begin
                if (s_q.in_frame) begin
                    s_d.word = fmt_word;
                end else begin
                    s_d.word = SYNC_WORD;
                    if (!q_empty) begin
                        q_pop     = 1'b1;
                        s_d.frame = q_dout;
                        s_d.armed = 1'b1;
                    end
                end
            end else begin
                s_d.word = {MK_STATUS, status_i[7:1], status_i[0] | s_q.ovf};
                s_d.ovf  = 1'b0;
                if (s_q.in_frame) begin
                    if (s_q.fidx == IDX_W'(FRAME_WORDS - 1)) s_d.in_frame = 1'b0;
                    else                                     s_d.fidx     = s_q.fidx + 1'b1;
                end else if (s_q.armed) begin
                    s_d.armed    = 1'b0;
                    s_d.in_frame = 1'b1;
                    s_d.fidx     = '0;
                end
            end
        end

        if (q_drop) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign word_o     = s_q.word;
    assign word_stb_o = s_q.stb;
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             trig_i,
    input logic [10:0]      word_o,
    input logic             word_stb_o,
    input logic             q_full,
    input logic             q_pop,
    input logic [CNT_W-1:0] q_cnt,
    input logic             ovf_q
);
    logic odd_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)           odd_q <= 1'b0;
        else if (word_stb_o) odd_q <= ~odd_q;
    end

    AST_STB_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        word_stb_o |=> !word_stb_o); // R2
    AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !word_stb_o |-> $stable(word_o)); // R2
    AST_SYNC_UNIQUE: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_stb_o && word_o[10:8] == 3'b000) |-> (word_o == 11'b000_0000_0001)); // R3
    AST_STATUS_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_stb_o && odd_q) |-> (word_o[10:8] == 3'b111)); // R4
    AST_FIRST_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_stb_o && !odd_q) |-> (word_o[10:8] != 3'b111)); // R6
    AST_QUEUE_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        q_cnt <= CNT_W'(FIFO_DEPTH)); // R8
    AST_DROP_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (trig_i && q_full && !q_pop) |=> ovf_q); // R9
endmodule

bind slice_frame_seq sfs_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .trig_i     (trig_i),
    .word_o     (word_o),
    .word_stb_o (word_stb_o),
    .q_full     (q_full),
    .q_pop      (q_pop),
    .q_cnt      (q_cnt),
    .ovf_q      (s_q.ovf)
);

// File: tb/sim_slice_frame_seq.sv
module sim_slice_frame_seq;
    localparam int CPW   = 3;
    localparam int DEPTH = 2;
    localparam logic [10:0] SYNC = 11'b000_0000_0001;

    logic        clk = 0;
    logic        rst = 1;
    logic        trig = 0;
    logic [63:0] hits = '0;
    logic [23:0] ts = '0;
    logic [7:0]  status = 8'hA4;
    logic [10:0] word_o;
    logic        word_stb_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    slice_frame_seq #(.HIT_W(64), .TS_W(24), .FIFO_DEPTH(DEPTH), .CLK_PER_WORD(CPW)) u0 (
        .clk_i(clk), .rst_i(rst), .trig_i(trig), .hits_i(hits), .tstamp_i(ts),
        .status_i(status), .word_o(word_o), .word_stb_o(word_stb_o)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_div, m_slot, m_inf, m_fidx, m_arm, m_ovf;
    logic [87:0] m_frame;
    logic [87:0] mq[$];
    logic [10:0] e_word;
    logic        e_stb;

    function automatic logic [10:0] frame_word(logic [87:0] f, int k);
        if (k == 0) return SYNC;
        if (k <= 3) return {3'b110, f[(k-1)*8 +: 8]};
        return {3'b101, f[24 + (k-4)*8 +: 8]};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_div = 0; m_slot = 0; m_inf = 0; m_fidx = 0; m_arm = 0; m_ovf = 0;
            mq.delete(); e_word = '0; e_stb = 0; m_frame = '0;
        end else begin
            bit tick, clr;
            tick  = (m_div == CPW - 1);
            m_div = tick ? 0 : m_div + 1;
            e_stb = 0;
            clr   = 0;
            if (tick) begin
                e_stb = 1;
                if (m_slot == 0) begin
                    if (m_inf != 0) e_word = frame_word(m_frame, m_fidx);
                    else begin
                        e_word = SYNC;
                        if (mq.size() > 0) begin m_frame = mq.pop_front(); m_arm = 1; end
                    end
                end else begin
                    e_word = {3'b111, status[7:1], status[0] | (m_ovf != 0)};
                    clr = 1;
                    if (m_inf != 0) begin
                        if (m_fidx == 11) m_inf = 0; else m_fidx++;
                    end else if (m_arm != 0) begin
                        m_arm = 0; m_inf = 1; m_fidx = 0;
                    end
                end
                m_slot = 1 - m_slot;
            end
            if (clr) m_ovf = 0;
            if (trig) begin
                if (mq.size() < DEPTH) mq.push_back({hits, ts});
                else m_ovf = 1;
            end
        end
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    logic [10:0] got[$];

    always @(negedge clk) begin
        if (!rst) begin
            chk(word_stb_o == e_stb, "R2 strobe", 64'(word_stb_o), 64'(e_stb));
            if (e_stb) begin
                chk(word_o == e_word, "R7 word vs model", 64'(word_o), 64'(e_word));
                got.push_back(word_o);
            end
        end
    end

    function automatic int find_time(int from);
        for (int j = from; j < got.size(); j++)
            if (got[j][10:8] == 3'b110) return j;
        return -1;
    endfunction

    task automatic check_frame(int j, logic [23:0] t, logic [63:0] h);
        if (j < 4) begin chk(0, "R6 frame located", 64'(j), 64'(4)); return; end
        chk(got[j-4] == SYNC, "R6 triggered slice sync", 64'(got[j-4]), 64'(SYNC));
        chk(got[j-3][10:8] == 3'b111, "R6 triggered slice status", 64'(got[j-3]), 64'(3'b111));
        chk(got[j-2] == SYNC, "R7 frame sync", 64'(got[j-2]), 64'(SYNC));
        for (int k = 0; k < 3; k++)
            chk(got[j+2*k] == {3'b110, t[k*8 +: 8]}, "R7 time word",
                64'(got[j+2*k]), 64'({3'b110, t[k*8 +: 8]}));
        for (int k = 0; k < 8; k++)
            chk(got[j+6+2*k] == {3'b101, h[k*8 +: 8]}, "R10 data word",
                64'(got[j+6+2*k]), 64'({3'b101, h[k*8 +: 8]}));
        for (int k = -1; k < 22; k += 2)
            chk(got[j+k][10:8] == 3'b111, "R6 status in frame slice", 64'(got[j+k]), 64'(3'b111));
        chk(got[j+22] == SYNC, "R6 idle sync after frame", 64'(got[j+22]), 64'(SYNC));
    endtask

    task automatic fire(logic [23:0] t, logic [63:0] h);
        @(negedge clk); trig = 1; ts = t; hits = h;
        @(negedge clk); trig = 0; ts = ~t; hits = ~h;
    endtask

    task automatic wait_words(int n);
        while (got.size() < n) @(negedge clk);
    endtask

    initial begin
        int base, j2, j3, seen;
        repeat (5) @(negedge clk);
        chk(word_o == 11'd0 && word_stb_o == 0, "R1 reset state", 64'({word_stb_o, word_o}), 64'd0);
        rst = 0;

        wait_words(4);
        chk(got[0] == SYNC, "R3 sync value", 64'(got[0]), 64'(SYNC));
        chk(got[1] == {3'b111, 8'hA4}, "R5 status word", 64'(got[1]), 64'({3'b111, 8'hA4}));
        chk(got[2] == SYNC, "R4 idle sync", 64'(got[2]), 64'(SYNC));
        chk(got[3] == {3'b111, 8'hA4}, "R4 idle status", 64'(got[3]), 64'({3'b111, 8'hA4}));

        // single triggered frame, inputs change right after trigger (R10)
        base = got.size();
        fire(24'h3C_5A_96, 64'h0123_4567_89AB_CDEF);
        wait_words(base + 40);
        check_frame(find_time(base), 24'h3C_5A_96, 64'h0123_4567_89AB_CDEF);

        // second trigger queued during a running frame (R8)
        status = 8'h5B;
        base = got.size();
        fire(24'h11_22_33, 64'hFEDC_BA98_7654_3210);
        repeat (20) @(negedge clk);
        fire(24'h44_55_66, 64'hA5A5_0F0F_3C3C_9696);
        wait_words(base + 70);
        j2 = find_time(base);
        check_frame(j2, 24'h11_22_33, 64'hFEDC_BA98_7654_3210);
        j3 = find_time(j2 + 22);
        chk(j3 == j2 + 26, "R8 back-to-back frame", 64'(j3), 64'(j2 + 26));
        check_frame(j3, 24'h44_55_66, 64'hA5A5_0F0F_3C3C_9696);

        // overflow: four consecutive triggers into a depth-2 queue (R9)
        status = 8'h5A;
        repeat (20) @(negedge clk);
        base = got.size();
        @(negedge clk); trig = 1; ts = 24'hAAAAAA; hits = 64'h1;
        repeat (4) @(negedge clk);
        trig = 0;
        wait_words(base + 8);
        seen = 0;
        for (int k = base; k < got.size(); k++)
            if (got[k][10:8] == 3'b111 && got[k][0]) seen++;
        chk(seen == 1, "R9 drop reported once", 64'(seen), 64'd1);
        repeat (400) @(negedge clk);
        chk(got[got.size()-1] == {3'b111, 8'h5A} || got[got.size()-2] == {3'b111, 8'h5A},
            "R9 drop flag cleared", 64'(got[got.size()-1]), 64'({3'b111, 8'h5A}));

        done = 1;
        finish_run();
    end
endmodule